// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Trigger Thresholds

This block holds the byte queues of one UART channel. It has a 64-entry queue in each direction. The host pushes transmit bytes, and the serial transmitter drains them. The serial receiver deposits bytes, and the host reads them back. A write-only control byte sets up the block. It selects whether the queues are in use, which fill thresholds raise the trigger flags, and a stored DMA signalling mode bit. It also issues one-shot flush commands for either direction.

When the queues are switched off, each direction holds a single byte, like a plain holding register. Turning the enable on or off empties both directions. The receive trigger compares the number of bytes held with one of four thresholds. The transmit trigger compares the free space with one of four other thresholds. The transmit threshold field is protected: it changes only while the enhanced-function input is high.

Three byte interfaces use valid/ready. A transfer happens in a cycle where both valid and ready are high. `tx_in_ready` is high exactly when the transmit queue is not full, and it does not depend on `tx_in_valid`. `tx_out_valid` and `rx_out_valid` are high whenever their queue holds a byte, and the data shown is the oldest byte. The receive deposit side cannot be back-pressured. A byte offered while the receive queue is full, with no read in the same cycle, is lost and recorded in the overrun flag.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset, both counts are 0, both empty flags are high, both trigger flags are low, and the enable, DMA mode and overrun outputs are all low.
- R2: While control bit 0 is stored as 0, each direction holds at most one byte. A full transmit side drops `tx_in_ready`, and a second receive byte is lost.
- R3: While control bit 0 is 1, each direction holds 64 bytes in arrival order. The full flag rises at 64, and a transmit offer to a full queue is not taken.
- R4: Control bits 7:6 pick the receive threshold: 00 = 8, 01 = 16, 10 = 56, 11 = 60. `rx_trig` is high while the queues are enabled and the receive count is at or above the threshold.
- R5: Control bits 5:4 pick the transmit threshold: 00 = 8, 01 = 16, 10 = 32, 11 = 56. `tx_trig` is high while the queues are enabled and the free space (64 minus the count) is at or above the threshold. It is low while the queues are disabled.
- R6: A control write changes the stored transmit threshold code only when `enh_en` is high. Otherwise the earlier code stays in force. The code is 00 after reset.
- R7: A control write with bit 2 set empties the transmit queue by the next cycle. The command acts once: later writes with bit 2 clear leave the queue alone. The receive queue is not affected.
- R8: A control write with bit 1 set empties the receive queue and clears the overrun flag by the next cycle. The transmit queue is not affected.
- R9: A control write that changes bit 0 updates `fifo_en` and empties both queues. A write that repeats the stored bit 0 empties neither.
- R10: A receive byte that arrives while the receive queue is full, with no read in the same cycle, is dropped. It sets `rx_overrun`, which stays high until a receive flush.
- R11: `dma_mode` shows control bit 3 from the last control write.
- R12: A push and a pop in the same cycle leave the count unchanged. A receive byte that arrives while the queue is full is kept if a read happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte |
| enh_en | input | 1 | Enhanced-function enable; unlocks the transmit threshold field |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue can take a byte |
| tx_in_data | input | 8 | Transmit byte from host |
| tx_out_valid | output | 1 | Transmit byte available to the serializer |
| tx_out_ready | input | 1 | Serializer takes the byte |
| tx_out_data | output | 8 | Oldest transmit byte |
| rx_in_valid | input | 1 | Deserializer delivers a byte |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Received byte available to host |
| rx_out_ready | input | 1 | Host reads the byte |
| rx_out_data | output | 8 | Oldest received byte |
| rx_trig | output | 1 | Receive fill at or above threshold |
| tx_trig | output | 1 | Transmit free space at or above threshold |
| rx_count | output | 7 | Bytes held in receive queue |
| tx_count | output | 7 | Bytes held in transmit queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| rx_overrun | output | 1 | Sticky receive overrun |
| dma_mode | output | 1 | Stored DMA signalling mode |
| fifo_en | output | 1 | Stored queue enable |

## Verification
The bench moves each receive threshold boundary by one byte and rewrites the threshold code at a fixed fill. A decoder with swapped or off-by-one levels therefore shows a trigger that is early, late or unchanged. The transmit threshold is rewritten with `enh_en` low and then high. A design that ignores the write protection moves the trigger at the wrong time. Each flush is checked against the other direction's count, and a write that only repeats the enable bit is checked to empty nothing. Flushes that are not one-shot, or that reach both queues, show up as counts lost there. The bench also pushes into a full receive queue with and without a same-cycle read, and checks the order of every byte drained. Wrong overrun handling shows up either as a spurious or missing sticky flag or as a byte that is lost or duplicated.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
  // Receive threshold in bytes held, selected by control bits 7:6.
  function automatic int unsigned rx_level(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 56;
      default: return 60;
    endcase
  endfunction

  // Transmit threshold in free slots, selected by control bits 5:4.
  function automatic int unsigned tx_level(input logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 32;
      default: return 56;
    endcase
  endfunction

  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       dma;
    logic       en;
  } ufp_cfg_t;
endpackage

// File: rtl/ufp_ctrl.sv
module ufp_ctrl
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       enh_en,
  output ufp_cfg_t   cfg,
  output logic       flush_tx,
  output logic       flush_rx
);
  logic en_change;

  assign en_change = we && (wdata[0] != cfg.en);
  // Flush commands are pulses, never stored.
  assign flush_tx  = (we && wdata[2]) || en_change;
  assign flush_rx  = (we && wdata[1]) || en_change;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.rx_code <= wdata[7:6];
      cfg.dma     <= wdata[3];
      cfg.en      <= wdata[0];
      if (enh_en) cfg.tx_code <= wdata[5:4];
    end
  end
endmodule

// File: rtl/ufp_fifo.sv
module ufp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout = mem[rp];
endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_data,
  input  logic          enh_en,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [7:0]    tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [7:0]    tx_out_data,
  input  logic          rx_in_valid,
  input  logic [7:0]    rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [7:0]    rx_out_data,
  output logic          rx_trig,
  output logic          tx_trig,
  output logic [CW-1:0] rx_count,
  output logic [CW-1:0] tx_count,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          tx_empty,
  output logic          tx_full,
  output logic          rx_overrun,
  output logic          dma_mode,
  output logic          fifo_en
);
  ufp_cfg_t     cfg;
  logic         flush_tx, flush_rx;
  logic [CW-1:0] cap, tx_free;
  logic         tx_push, tx_pop, rx_push, rx_pop;

  ufp_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_data),
    .enh_en   (enh_en),
    .cfg      (cfg),
    .flush_tx (flush_tx),
    .flush_rx (flush_rx)
  );

  // Disabled queues behave as one-byte holding registers.
  assign cap = cfg.en ? CW'(DEPTH) : CW'(1);

  assign tx_full      = (tx_count >= cap);
  assign tx_empty     = (tx_count == '0);
  assign rx_full      = (rx_count >= cap);
  assign rx_empty     = (rx_count == '0);

  assign tx_in_ready  = !tx_full;
  assign tx_out_valid = !tx_empty;
  assign rx_out_valid = !rx_empty;

  assign tx_push = tx_in_valid && tx_in_ready;
  assign tx_pop  = tx_out_valid && tx_out_ready;
  assign rx_pop  = rx_out_valid && rx_out_ready;
  assign rx_push = rx_in_valid && (!rx_full || rx_pop);

  ufp_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_q (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_tx),
    .push  (tx_push),
    .pop   (tx_pop),
    .din   (tx_in_data),
    .dout  (tx_out_data),
    .count (tx_count)
  );

  ufp_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_q (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush_rx),
    .push  (rx_push),
    .pop   (rx_pop),
    .din   (rx_in_data),
    .dout  (rx_out_data),
    .count (rx_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  rx_overrun <= 1'b0;
    else if (flush_rx)                           rx_overrun <= 1'b0;
    else if (rx_in_valid && rx_full && !rx_pop)  rx_overrun <= 1'b1;
  end

  assign tx_free  = cap - tx_count;
  assign rx_trig  = cfg.en && (rx_count >= CW'(rx_level(cfg.rx_code)));
  assign tx_trig  = cfg.en && (tx_free  >= CW'(tx_level(cfg.tx_code)));
  assign dma_mode = cfg.dma;
  assign fifo_en  = cfg.en;
endmodule

// File: rtl/uart_fifo_pair_chk.sv
module uart_fifo_pair_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_data,
  input logic          tx_in_ready,
  input logic          tx_full,
  input logic          rx_trig,
  input logic          tx_trig,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] tx_count,
  input logic          rx_overrun,
  input logic          fifo_en
);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  a_r3_full_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    tx_full |-> !tx_in_ready);

  a_r2_disabled_depth: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (rx_count <= 1) && (tx_count <= 1));

  a_r7_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_data[2]) |=> (tx_count == '0));

  a_r8_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_data[1]) |=> (rx_count == '0) && !rx_overrun);

  a_r9_enable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_data[0] != fifo_en)) |=> (rx_count == '0) && (tx_count == '0));

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !(cfg_we && (cfg_data[1] || (cfg_data[0] != fifo_en))))
      |=> rx_overrun);

  a_r4_rx_trig_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig |-> (rx_count >= 8) && fifo_en);

  a_r5_tx_trig_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig |-> fifo_en && (tx_count <= CW'(DEPTH - 8)));
endmodule

bind uart_fifo_pair uart_fifo_pair_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we, enh_en;
  logic [7:0] cfg_data;
  logic       tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
  logic [7:0] tx_in_data, tx_out_data;
  logic       rx_in_valid, rx_out_valid, rx_out_ready;
  logic [7:0] rx_in_data, rx_out_data;
  logic       rx_trig, tx_trig, rx_empty, rx_full, tx_empty, tx_full;
  logic       rx_overrun, dma_mode, fifo_en;
  logic [6:0] rx_count, tx_count;

  int   n_vec = 0;
  int   n_bad = 0;
  logic m_en  = 1'b0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  always #5 clk = ~clk;

  uart_fifo_pair u_uart_fifo_pair (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] d, input logic e);
    cfg_we = 1'b1; cfg_data = d; enh_en = e;
    @(negedge clk);
    cfg_we = 1'b0;
    if (d[2] || (d[0] != m_en)) txq.delete();
    if (d[1] || (d[0] != m_en)) rxq.delete();
    m_en = d[0];
  endtask

  task automatic tx_push(input logic [7:0] b);
    tx_in_valid = 1'b1; tx_in_data = b;
    @(negedge clk);
    tx_in_valid = 1'b0;
    txq.push_back(b);
  endtask

  task automatic rx_push(input logic [7:0] b);
    rx_in_valid = 1'b1; rx_in_data = b;
    @(negedge clk);
    rx_in_valid = 1'b0;
    if (rxq.size() < (m_en ? 64 : 1)) rxq.push_back(b);
  endtask

  // Monitor side: pop the oldest expected item and compare.
  task automatic tx_pop(input string tag);
    chk({tag, " tx valid"}, int'(tx_out_valid), 1);
    chk({tag, " tx data"}, int'(tx_out_data), int'(txq[0]));
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_out_ready = 1'b0;
    void'(txq.pop_front());
  endtask

  task automatic rx_pop(input string tag);
    chk({tag, " rx valid"}, int'(rx_out_valid), 1);
    chk({tag, " rx data"}, int'(rx_out_data), int'(rxq[0]));
    rx_out_ready = 1'b1;
    @(negedge clk);
    rx_out_ready = 1'b0;
    void'(rxq.pop_front());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_data = '0; enh_en = 1'b0;
    tx_in_valid = 1'b0; tx_in_data = '0; tx_out_ready = 1'b0;
    rx_in_valid = 1'b0; rx_in_data = '0; rx_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rx_count", int'(rx_count), 0);
    chk("R1 tx_count", int'(tx_count), 0);
    chk("R1 empties", int'({rx_empty, tx_empty}), 3);
    chk("R1 triggers", int'({rx_trig, tx_trig}), 0);
    chk("R1 en/dma/ovr", int'({fifo_en, dma_mode, rx_overrun}), 0);

    // R2 holding-register mode
    tx_push(8'hA5);
    chk("R2 tx_count", int'(tx_count), 1);
    chk("R2 tx_in_ready", int'(tx_in_ready), 0);
    tx_pop("R2");
    rx_push(8'h11);
    rx_push(8'h22);
    chk("R2 rx_count", int'(rx_count), 1);
    chk("R10 overrun set", int'(rx_overrun), 1);
    rx_pop("R2");
    cfg(8'h02, 1'b0);
    chk("R8 overrun cleared", int'(rx_overrun), 0);

    // R9 enabling flushes both directions
    tx_push(8'h33);
    rx_push(8'h44);
    cfg(8'h01, 1'b0);
    chk("R9 fifo_en", int'(fifo_en), 1);
    chk("R9 tx flushed", int'(tx_count), 0);
    chk("R9 rx flushed", int'(rx_count), 0);

    // R4 receive thresholds
    for (int i = 0; i < 7; i++) rx_push(8'(i));
    chk("R4 code0 at 7", int'(rx_trig), 0);
    rx_push(8'd7);
    chk("R4 code0 at 8", int'(rx_trig), 1);
    cfg(8'h41, 1'b0);
    chk("R9 no flush same en", int'(rx_count), 8);
    chk("R4 code1 at 8", int'(rx_trig), 0);
    for (int i = 8; i < 15; i++) rx_push(8'(i));
    chk("R4 code1 at 15", int'(rx_trig), 0);
    rx_push(8'd15);
    chk("R4 code1 at 16", int'(rx_trig), 1);
    cfg(8'h81, 1'b0);
    chk("R4 code2 at 16", int'(rx_trig), 0);
    for (int i = 16; i < 55; i++) rx_push(8'(i));
    chk("R4 code2 at 55", int'(rx_trig), 0);
    rx_push(8'd55);
    chk("R4 code2 at 56", int'(rx_trig), 1);
    cfg(8'hC1, 1'b0);
    chk("R4 code3 at 56", int'(rx_trig), 0);
    for (int i = 56; i < 59; i++) rx_push(8'(i));
    chk("R4 code3 at 59", int'(rx_trig), 0);
    rx_push(8'd59);
    chk("R4 code3 at 60", int'(rx_trig), 1);
    for (int i = 60; i < 64; i++) rx_push(8'(i));
    chk("R3 rx full", int'(rx_full), 1);
    chk("R3 rx_count 64", int'(rx_count), 64);
    chk("R10 no overrun yet", int'(rx_overrun), 0);
    rx_push(8'hFF);
    chk("R10 overrun", int'(rx_overrun), 1);
    chk("R10 byte dropped", int'(rx_count), 64);
    cfg(8'hC3, 1'b0);
    chk("R8 rx flushed", int'(rx_count), 0);
    chk("R8 overrun cleared", int'(rx_overrun), 0);

    // R12 receive push into full with same-cycle read
    for (int i = 0; i < 64; i++) rx_push(8'(i + 100));
    chk("R12 rx full", int'(rx_full), 1);
    chk("R12 rx head", int'(rx_out_data), int'(rxq[0]));
    rx_in_valid = 1'b1; rx_in_data = 8'hEE; rx_out_ready = 1'b1;
    @(negedge clk);
    rx_in_valid = 1'b0; rx_out_ready = 1'b0;
    void'(rxq.pop_front());
    rxq.push_back(8'hEE);
    chk("R12 rx_count kept", int'(rx_count), 64);
    chk("R12 no overrun", int'(rx_overrun), 0);
    repeat (64) rx_pop("R3");
    chk("R3 rx drained", int'(rx_empty), 1);

    // R5/R6 transmit thresholds
    for (int i = 0; i < 40; i++) tx_push(8'(i + 1));
    chk("R5 code0 free24", int'(tx_trig), 1);
    cfg(8'h31, 1'b0);
    chk("R6 locked code", int'(tx_trig), 1);
    cfg(8'h31, 1'b1);
    chk("R5 code3 free24", int'(tx_trig), 0);
    cfg(8'h21, 1'b1);
    chk("R5 code2 free24", int'(tx_trig), 0);
    cfg(8'h11, 1'b1);
    chk("R5 code1 free24", int'(tx_trig), 1);
    cfg(8'h01, 1'b1);
    for (int i = 40; i < 56; i++) tx_push(8'(i + 1));
    chk("R5 code0 free8", int'(tx_trig), 1);
    tx_push(8'd57);
    chk("R5 code0 free7", int'(tx_trig), 0);
    for (int i = 57; i < 64; i++) tx_push(8'(i + 1));
    chk("R3 tx full", int'(tx_full), 1);
    chk("R3 tx not ready", int'(tx_in_ready), 0);
    tx_in_valid = 1'b1; tx_in_data = 8'hBB;
    @(negedge clk);
    tx_in_valid = 1'b0;
    chk("R3 tx offer refused", int'(tx_count), 64);
    tx_pop("R3");
    chk("R12 tx head", int'(tx_out_data), int'(txq[0]));
    tx_in_valid = 1'b1; tx_in_data = 8'h77; tx_out_ready = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0; tx_out_ready = 1'b0;
    void'(txq.pop_front());
    txq.push_back(8'h77);
    chk("R12 tx_count kept", int'(tx_count), 63);
    repeat (3) tx_pop("R3");

    // R7 transmit flush, one-shot, receive side untouched
    rx_push(8'h55);
    cfg(8'h05, 1'b1);
    chk("R7 tx flushed", int'(tx_count), 0);
    chk("R7 tx empty", int'(tx_empty), 1);
    chk("R7 rx untouched", int'(rx_count), 1);
    tx_push(8'h66);
    cfg(8'h01, 1'b1);
    chk("R7 one-shot", int'(tx_count), 1);
    cfg(8'h03, 1'b1);
    chk("R8 rx flushed", int'(rx_count), 0);
    chk("R8 tx untouched", int'(tx_count), 1);
    tx_pop("R7");

    // R11 DMA mode bit
    cfg(8'h09, 1'b1);
    chk("R11 dma set", int'(dma_mode), 1);
    cfg(8'h01, 1'b1);
    chk("R11 dma clear", int'(dma_mode), 0);

    // R9 disabling flushes; R5 trigger low when disabled
    tx_push(8'h01);
    cfg(8'h00, 1'b1);
    chk("R9 fifo_en off", int'(fifo_en), 0);
    chk("R9 tx flushed", int'(tx_count), 0);
    chk("R5 disabled trig", int'(tx_trig), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule